// File: doc/BRIEF.md
# PC-Relative Store Micro-Sequencer

This block is the control and datapath slice that carries out a PC-relative store on a 16-bit processor. All operand movement goes over one internal bus. The effective address is the program counter plus a sign-extended 9-bit offset taken from the instruction. The word stored is the register that a 3-bit field of the instruction selects. Nothing reaches a holding register directly. In each cycle one source is gated onto the bus and one register latches it. For this reason the store runs as a fixed three-step micro-sequence, and each step starts only after the register loaded in the step before has settled.

The controller is a four-state machine. `SEQ_IDLE` waits for `start`. `SEQ_ADDR` sets the adder path to PC plus offset, gates the address-source mux onto the bus and loads the address register. `SEQ_DATA` selects the source-register field, sets the ALU to pass its A operand, gates the ALU onto the bus and loads the data register from the bus. `SEQ_WRITE` enables the memory interface with write asserted. The transitions are: IDLE→ADDR when `start` is high, ADDR→DATA, DATA→WRITE and WRITE→IDLE, each taken unconditionally. The cycle after WRITE carries a one-cycle `done` pulse. The environment holds the instruction fields stable from the start request until the write cycle. Instruction fetch, decode of other opcodes, condition codes and memory wait states belong to the rest of the processor.

Top module: `pcrel_store_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `done`, `mem_en` and `mem_we` are 0, and `mem_addr` and `mem_wdata` are 0.
- R2: During the write cycle `mem_addr` equals `pc` plus the sign extension of `instr_fields[8:0]` (bit 8 is the sign), modulo 2^16, where `pc` is the value sampled when the address step ends.
- R3: During the data step `rf_sel` equals `instr_fields[11:9]`, and during the write cycle `mem_wdata` equals the register word returned on `rf_data` for that index.
- R4: `start` sampled high while idle begins a store whose address step, data step and write cycle fall in three consecutive cycles. `mem_en` and `mem_we` are high together in the third cycle only, so each store performs exactly one write.
- R5: At most one bus driver is gated in any cycle.
- R6: `done` is high for exactly the one cycle that follows the write cycle, and `busy` is low in that cycle.
- R7: `start` has no effect while `busy` is high: holding it high through a store neither restarts nor extends the sequence.
- R8: The address register changes only on the address step and the data register only on the data step. Changes on `pc` after the address step, or on `rf_data` after the data step, do not alter the written address or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a store, sampled while idle |
| instr_fields | input | 12 | Low instruction bits: [11:9] source register, [8:0] signed offset |
| pc | input | 16 | Program counter value |
| rf_data | input | 16 | Register-file read data for `rf_sel` |
| rf_sel | output | 3 | Register-file read index |
| mem_en | output | 1 | Memory interface enable |
| mem_we | output | 1 | Memory write strobe, valid with `mem_en` |
| mem_addr | output | 16 | Address register contents |
| mem_wdata | output | 16 | Data register contents |
| busy | output | 1 | High while a store is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check, in every cycle, that no more than one bus gate is active and that each state moves on to the next in order. They also check that a data load is always followed by a write cycle, that `done` comes only after a write, that both holding registers keep their value outside their own load step, and that `start` never restarts a store already under way. The arithmetic can only be shown by the bench's scenarios. These cover the written address for every one of the 512 offsets, negative ones included, and wraparound past the top of memory. They also check that the written word matches the selected register. The bench changes `pc` and the register contents in mid-store and confirms the write ignores the change, and it holds `start` high through a whole store.

// File: rtl/pcrel_store_pkg.sv
package pcrel_store_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ADDR  = 2'd1,
        SEQ_DATA  = 2'd2,
        SEQ_WRITE = 2'd3
    } seq_state_t;

    // first adder operand
    typedef enum logic { A1_PC = 1'b0, A1_BASE = 1'b1 } addr1_sel_t;
    // second adder operand
    typedef enum logic { A2_ZERO = 1'b0, A2_OFS = 1'b1 } addr2_sel_t;
    // address-source mux ahead of the bus gate
    typedef enum logic { MS_ADDER = 1'b0, MS_IRLOW = 1'b1 } marsrc_sel_t;
    // which instruction field names the register to read
    typedef enum logic { SRF_HI = 1'b0, SRF_MID = 1'b1 } srcfld_sel_t;
    typedef enum logic { ALU_PASS_A = 1'b0, ALU_NOT_A = 1'b1 } alu_op_t;

    typedef struct packed {
        addr1_sel_t  a1;
        addr2_sel_t  a2;
        marsrc_sel_t msrc;
        logic        gate_mar;
        srcfld_sel_t srf;
        alu_op_t     aluop;
        logic        gate_alu;
        logic        mio_en;
        logic        wr;
        logic        ld_mar;
        logic        ld_mdr;
    } ctl_t;

endpackage

// File: rtl/pcrel_store_ctrl.sv
module pcrel_store_ctrl
    import pcrel_store_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output ctl_t ctl,
    output logic busy,
    output logic done
);

    seq_state_t state_q, state_d;
    logic       done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (start) state_d = SEQ_ADDR;
            SEQ_ADDR:  state_d = SEQ_DATA;
            SEQ_DATA:  state_d = SEQ_WRITE;
            SEQ_WRITE: state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == SEQ_WRITE);
        end
    end

    always_comb begin
        ctl          = '0;
        ctl.a1       = A1_PC;
        ctl.a2       = A2_ZERO;
        ctl.msrc     = MS_ADDER;
        ctl.srf      = SRF_HI;
        ctl.aluop    = ALU_PASS_A;
        unique case (state_q)
            SEQ_IDLE: begin
            end
            SEQ_ADDR: begin
                ctl.a1       = A1_PC;
                ctl.a2       = A2_OFS;
                ctl.msrc     = MS_ADDER;
                ctl.gate_mar = 1'b1;
                ctl.ld_mar   = 1'b1;
            end
            SEQ_DATA: begin
                ctl.srf      = SRF_HI;
                ctl.aluop    = ALU_PASS_A;
                ctl.gate_alu = 1'b1;
                ctl.mio_en   = 1'b0;
                ctl.ld_mdr   = 1'b1;
            end
            SEQ_WRITE: begin
                ctl.mio_en   = 1'b1;
                ctl.wr       = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign busy = (state_q != SEQ_IDLE);
    assign done = done_q;

    p_addr_then_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_ADDR) |=> (state_q == SEQ_DATA));
    p_data_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_DATA) |=> (state_q == SEQ_WRITE));
    p_write_then_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_WRITE) |=> (state_q == SEQ_IDLE));
    p_done_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(ctl.wr && ctl.mio_en));
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_start_ignored_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state_q != SEQ_ADDR));

endmodule

// File: rtl/pcrel_store_path.sv
module pcrel_store_path
    import pcrel_store_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned OFS_W  = 9,
    parameter int unsigned RIDX_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  ctl_t                          ctl,
    input  logic [OFS_W+RIDX_W-1:0]       instr_fields,
    input  logic [WORD_W-1:0]             pc,
    input  logic [WORD_W-1:0]             rf_data,
    output logic [RIDX_W-1:0]             rf_sel,
    output logic [WORD_W-1:0]             mar_q,
    output logic [WORD_W-1:0]             mdr_q
);

    localparam int unsigned FLD_W   = OFS_W + RIDX_W;
    localparam int unsigned SRC_LO  = OFS_W;
    localparam int unsigned MID_LO  = OFS_W - RIDX_W;
    localparam int unsigned LOW_W   = OFS_W - 1;
    localparam int unsigned N_DRV   = 2;
    localparam int unsigned DRV_MAR = 0;
    localparam int unsigned DRV_ALU = 1;

    logic [WORD_W-1:0] ofs_sext, addr1_v, addr2_v, adder_v, marsrc_v;
    logic [WORD_W-1:0] alu_v, bus_v;
    logic [N_DRV-1:0]              gate_v;
    logic [N_DRV-1:0][WORD_W-1:0]  drv_v;

    assign ofs_sext = {{(WORD_W-OFS_W){instr_fields[OFS_W-1]}}, instr_fields[OFS_W-1:0]};

    always_comb begin
        unique case (ctl.a1)
            A1_PC:   addr1_v = pc;
            A1_BASE: addr1_v = rf_data;
            default: addr1_v = pc;
        endcase
        unique case (ctl.a2)
            A2_ZERO: addr2_v = '0;
            A2_OFS:  addr2_v = ofs_sext;
            default: addr2_v = '0;
        endcase
    end

    assign adder_v = addr1_v + addr2_v;

    always_comb begin
        unique case (ctl.msrc)
            MS_ADDER: marsrc_v = adder_v;
            MS_IRLOW: marsrc_v = {{(WORD_W-LOW_W){1'b0}}, instr_fields[LOW_W-1:0]};
            default:  marsrc_v = adder_v;
        endcase
    end

    always_comb begin
        unique case (ctl.srf)
            SRF_HI:  rf_sel = instr_fields[FLD_W-1:SRC_LO];
            SRF_MID: rf_sel = instr_fields[SRC_LO-1:MID_LO];
            default: rf_sel = instr_fields[FLD_W-1:SRC_LO];
        endcase
    end

    always_comb begin
        unique case (ctl.aluop)
            ALU_PASS_A: alu_v = rf_data;
            ALU_NOT_A:  alu_v = ~rf_data;
            default:    alu_v = rf_data;
        endcase
    end

    assign gate_v[DRV_MAR] = ctl.gate_mar;
    assign gate_v[DRV_ALU] = ctl.gate_alu;
    assign drv_v[DRV_MAR]  = marsrc_v;
    assign drv_v[DRV_ALU]  = alu_v;

    // shared bus: gated sources merged, at most one enabled
    always_comb begin
        bus_v = '0;
        for (int d = 0; d < N_DRV; d++) begin
            bus_v = bus_v | ({WORD_W{gate_v[d]}} & drv_v[d]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mar_q <= '0;
            mdr_q <= '0;
        end else begin
            if (ctl.ld_mar) mar_q <= bus_v;
            if (ctl.ld_mdr && !ctl.mio_en) mdr_q <= bus_v;
        end
    end

    p_single_driver_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_v));
    p_mar_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.ld_mar |=> $stable(mar_q));
    p_mdr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.ld_mdr |=> $stable(mdr_q));
    p_write_after_mdr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ld_mdr |=> (ctl.mio_en && ctl.wr));

endmodule

// File: rtl/pcrel_store_unit.sv
module pcrel_store_unit
    import pcrel_store_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned OFS_W  = 9,
    parameter int unsigned RIDX_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [OFS_W+RIDX_W-1:0] instr_fields,
    input  logic [WORD_W-1:0]       pc,
    input  logic [WORD_W-1:0]       rf_data,
    output logic [RIDX_W-1:0]       rf_sel,
    output logic                    mem_en,
    output logic                    mem_we,
    output logic [WORD_W-1:0]       mem_addr,
    output logic [WORD_W-1:0]       mem_wdata,
    output logic                    busy,
    output logic                    done
);

    ctl_t ctl;

    pcrel_store_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    pcrel_store_path #(
        .WORD_W (WORD_W),
        .OFS_W  (OFS_W),
        .RIDX_W (RIDX_W)
    ) u_path (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl          (ctl),
        .instr_fields (instr_fields),
        .pc           (pc),
        .rf_data      (rf_data),
        .rf_sel       (rf_sel),
        .mar_q        (mem_addr),
        .mdr_q        (mem_wdata)
    );

    assign mem_en = ctl.mio_en;
    assign mem_we = ctl.wr;

    p_we_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);
    p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/test_pcrel_store_unit.sv
`timescale 1ns/1ps
module test_pcrel_store_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] instr_fields = '0;
    logic [15:0] pc = '0;
    logic [15:0] rf_data;
    logic [2:0]  rf_sel;
    logic        mem_en, mem_we, busy, done;
    logic [15:0] mem_addr, mem_wdata;

    logic [15:0] regs [8];
    int n_chk = 0;
    int n_bad = 0;
    int n_wr  = 0;
    int cyc   = 0;
    logic [15:0] cap_addr, cap_data;

    always #2.5 clk = ~clk;

    assign rf_data = regs[rf_sel];

    pcrel_store_unit i_pcrel_store_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .instr_fields(instr_fields),
        .pc(pc), .rf_data(rf_data), .rf_sel(rf_sel), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .done(done)
    );

    // memory model: capture each write at the clock edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && mem_en && mem_we) begin
            n_wr     <= n_wr + 1;
            cap_addr <= mem_addr;
            cap_data <= mem_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // mode 0 plain, 1 hold start, 2 disturb pc and registers mid-store
    task automatic run_store(input logic [15:0] p, input logic [11:0] f, input int mode);
        logic [15:0] exp_a, exp_d, pc0;
        int wr0;
        pc0   = p;
        exp_a = p + {{7{f[8]}}, f[8:0]};
        exp_d = regs[f[11:9]];
        wr0   = n_wr;
        @(negedge clk);
        pc = p; instr_fields = f; start = 1'b1;
        @(negedge clk);                          // address step
        if (mode != 1) start = 1'b0;
        check("R4 busy in address step", busy, 1);
        check("R4 no write in address step", mem_en, 0);
        @(negedge clk);                          // data step
        check("R3 rf_sel field", rf_sel, f[11:9]);
        check("R4 no write in data step", mem_en, 0);
        if (mode == 2) pc = ~pc0;
        @(negedge clk);                          // write cycle
        if (mode == 2) begin
            for (int k = 0; k < 8; k++) regs[k] = regs[k] ^ 16'h5A5A;
            #1;
        end
        check("R4 write enable", {mem_en, mem_we}, 2'b11);
        check("R2 effective address", mem_addr, exp_a);
        check("R3 write data", mem_wdata, exp_d);
        @(negedge clk);                          // completion cycle
        check("R6 done pulse", done, 1);
        check("R6 not busy with done", busy, 0);
        check("R4 single write per store", n_wr - wr0, 1);
        if (mode == 2) begin
            check("R8 address unaffected by pc change", cap_addr, exp_a);
            check("R8 data unaffected by register change", cap_data, exp_d);
        end else begin
            check("R2 captured address", cap_addr, exp_a);
            check("R3 captured data", cap_data, exp_d);
        end
        if (mode == 1) start = 1'b0;
        @(negedge clk);
        check("R6 done lasts one cycle", done, 0);
        check("R7 no restart", busy, 0);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) regs[k] = 16'h1000 * k[15:0] + 16'h0F0F;
        #12;
        @(negedge clk);
        check("R1 busy reset", busy, 0);
        check("R1 done reset", done, 0);
        check("R1 mem strobes reset", {mem_en, mem_we}, 0);
        check("R1 addr reset", mem_addr, 0);
        check("R1 data reset", mem_wdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", busy, 0);

        // sweep all offsets, every register index
        for (int i = 0; i < 512; i++) begin
            logic [11:0] f;
            logic [15:0] p;
            f = {3'(i % 8), 9'(i)};
            p = 16'(i * 16'd131 + 16'h3000);
            regs[i % 8] = 16'(i * 16'd977 + 16'h00C3);
            run_store(p, f, 0);
        end
        // wrap past top and below zero
        run_store(16'hFFF0, {3'd5, 9'h020}, 0);
        run_store(16'h0004, {3'd2, 9'h1F0}, 0);
        run_store(16'h8000, {3'd7, 9'h100}, 0);
        run_store(16'h7FFF, {3'd0, 9'h0FF}, 0);
        // start held high through a store
        run_store(16'h2222, {3'd3, 9'h1FF}, 1);
        run_store(16'h0100, {3'd6, 9'h005}, 1);
        // inputs changed after their load steps
        run_store(16'h4444, {3'd1, 9'h17A}, 2);
        run_store(16'hABCD, {3'd4, 9'h033}, 2);
        finish_run();
    end

    initial begin
        wait (cyc > 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        finish_run();
    end

endmodule